// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sorts each CPU bus address into one of six programmable address windows. Every window holds an upper-address base, a 16-bit thermometer size mask, a target identifier, an attribute byte and an enable flag. A request is an address with a valid strobe. One clock later the block returns a response. The response is either a hit, carrying the index, target and attribute of the winning window, or a miss with all of those fields at zero.

Software loads the windows through a small write port. Each write selects a window, a field and a data word. The size field counts 64 KB granules as a run of ones that starts at bit 0, so the value plus one is the window length in granules. That mask drives the address compare directly, and no adder or comparator chain is needed. A size value that is not such a run is reported as a configuration error, and the window is then kept out of the decode.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled, with base, size, target and attribute all zero. The response outputs and `cfg_err` are zero.
- R2: A write with `cfg_we` high updates the window named by `cfg_win` on the next clock edge. The field is chosen by `cfg_field`:
  - 0 loads the base from `cfg_wdata[31:16]`.
  - 1 loads the size from `cfg_wdata[15:0]`.
  - 2 loads the attribute from `cfg_wdata[7:0]` and the target from `cfg_wdata[11:8]`.
  - 3 loads the enable from `cfg_wdata[0]`.
  
  A write to window index 6 or 7 changes nothing. A request in the same cycle as a write is decoded with the old settings.
- R3: An enabled, well-formed window matches when the address bits [31:16] equal the base bits [31:16] at every bit position where the size field is 0. Address bits [15:0] are never compared.
- R4: A size of 0x0000 gives a window of exactly 64 KB.
- R5: A size of N ones gives a window of 2^N granules of 64 KB, aligned to its own length. For example, 0x00FF covers 16 MB and 0x0FFF covers 256 MB.
- R6: `cfg_err[i]` is 1 exactly when the size of window i is not of the form 2^N-1. Such a window never matches.
- R7: A window whose enable is 0 never matches.
- R8: When several windows match, the lowest-numbered one is reported.
- R9: `rsp_valid` equals `req_valid` one cycle earlier. A hit's index, target and attribute appear in that same cycle.
- R10: A miss, or a cycle with no request, gives `rsp_hit`=0 with `rsp_win`, `rsp_target` and `rsp_attr` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 3 | Window index of the write |
| cfg_field | input | 2 | Field selector of the write |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Address valid |
| req_addr | input | 32 | Address to decode |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | 3 | Index of the winning window |
| rsp_target | output | 4 | Target identifier of the winning window |
| rsp_attr | output | 8 | Attribute byte of the winning window |
| cfg_err | output | 6 | Per-window malformed-size flag |

## Verification
The bench builds the decoder with its default parameters: six windows, 32-bit addresses, a 16-bit size mask, a 4-bit target and an 8-bit attribute. With these defaults, the out-of-range window indices 6 and 7 are reachable through the 3-bit select, and so is every size from 64 KB up to 256 MB. The window layout overlaps one small window inside a large one, which exercises the priority order. It also breaks and then restores one size mask, disables windows, and changes settings while requests are in flight.

// File: rtl/awd_pkg.sv
package awd_pkg;

  localparam int unsigned SZ_W = 16;

  typedef enum logic [1:0] {
    FLD_BASE   = 2'd0,
    FLD_SIZE   = 2'd1,
    FLD_ROUTE  = 2'd2,
    FLD_ENABLE = 2'd3
  } cfg_field_e;

  // True when the mask is a run of ones starting at bit 0 (zero ones allowed).
  function automatic logic size_well_formed(input logic [SZ_W-1:0] sz);
    logic [SZ_W-1:0] nxt;
    nxt = sz + 1'b1;
    return ((sz & nxt) == '0);
  endfunction

  // Masked compare of the upper address against the base.
  function automatic logic upper_match(input logic [SZ_W-1:0] a_hi,
                                       input logic [SZ_W-1:0] b_hi,
                                       input logic [SZ_W-1:0] sz);
    return (((a_hi ^ b_hi) & ~sz) == '0);
  endfunction

endpackage

// File: rtl/awd_cfg_regs.sv
module awd_cfg_regs #(
  parameter int unsigned NUM_WIN = 6,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned TGT_W   = 4,
  parameter int unsigned ATTR_W  = 8,
  parameter int unsigned SIZE_W  = awd_pkg::SZ_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [IDX_W-1:0]                cfg_win,
  input  logic [1:0]                      cfg_field,
  input  logic [DATA_W-1:0]               cfg_wdata,
  output logic [NUM_WIN-1:0][SIZE_W-1:0]  base_hi,
  output logic [NUM_WIN-1:0][SIZE_W-1:0]  size_mask,
  output logic [NUM_WIN-1:0][TGT_W-1:0]   target,
  output logic [NUM_WIN-1:0][ATTR_W-1:0]  attr,
  output logic [NUM_WIN-1:0]              enable
);
  import awd_pkg::*;

  localparam int unsigned BASE_LSB = DATA_W - SIZE_W;

  cfg_field_e fld;
  assign fld = cfg_field_e'(cfg_field);

  logic [NUM_WIN-1:0] wr_sel;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    assign wr_sel[i] = cfg_we && (cfg_win == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_hi[i]   <= '0;
        size_mask[i] <= '0;
        target[i]    <= '0;
        attr[i]      <= '0;
        enable[i]    <= 1'b0;
      end else if (wr_sel[i]) begin
        unique case (fld)
          FLD_BASE:   base_hi[i]   <= cfg_wdata[BASE_LSB +: SIZE_W];
          FLD_SIZE:   size_mask[i] <= cfg_wdata[SIZE_W-1:0];
          FLD_ROUTE: begin
            attr[i]   <= cfg_wdata[ATTR_W-1:0];
            target[i] <= cfg_wdata[ATTR_W +: TGT_W];
          end
          FLD_ENABLE: enable[i]    <= cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  // R2
  one_window_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  // R2
  out_of_range_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (int'(cfg_win) >= NUM_WIN)) |=> $stable(enable) && $stable(size_mask)
      && $stable(base_hi) && $stable(target) && $stable(attr));

endmodule

// File: rtl/awd_win_match.sv
module awd_win_match #(
  parameter int unsigned SIZE_W = awd_pkg::SZ_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] addr_hi,
  input  logic [SIZE_W-1:0] base_hi,
  input  logic [SIZE_W-1:0] size_mask,
  input  logic              enable,
  output logic              hit,
  output logic              size_err
);
  import awd_pkg::*;

  logic raw_match;

  assign size_err  = !size_well_formed(size_mask);
  assign raw_match = upper_match(addr_hi, base_hi, size_mask);
  assign hit       = enable && !size_err && raw_match;

  // R6
  bad_size_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> !hit);

  // R7
  disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !hit);

  // R3
  base_itself_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !size_err && (addr_hi == base_hi)) |-> hit);

endmodule

// File: rtl/awd_prio_pick.sv
module awd_prio_pick #(
  parameter int unsigned N     = 6,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  assign grant = req & (~req + 1'b1);
  assign any   = |req;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  // R8
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R8
  grant_within_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

  // R8
  grant_when_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (grant[idx] && ((req & ((N'(1) << idx) - 1'b1)) == '0)));

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int unsigned NUM_WIN = 6,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned TGT_W   = 4,
  parameter int unsigned ATTR_W  = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_win,
  input  logic [1:0]         cfg_field,
  input  logic [ADDR_W-1:0]  cfg_wdata,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [IDX_W-1:0]   rsp_win,
  output logic [TGT_W-1:0]   rsp_target,
  output logic [ATTR_W-1:0]  rsp_attr,
  output logic [NUM_WIN-1:0] cfg_err
);
  import awd_pkg::*;

  localparam int unsigned SIZE_W   = SZ_W;
  localparam int unsigned GRAN_LSB = ADDR_W - SIZE_W;

  logic [NUM_WIN-1:0][SIZE_W-1:0] base_hi;
  logic [NUM_WIN-1:0][SIZE_W-1:0] size_mask;
  logic [NUM_WIN-1:0][TGT_W-1:0]  target;
  logic [NUM_WIN-1:0][ATTR_W-1:0] attr;
  logic [NUM_WIN-1:0]             enable;

  awd_cfg_regs #(
    .NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .DATA_W(ADDR_W),
    .TGT_W(TGT_W), .ATTR_W(ATTR_W), .SIZE_W(SIZE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .base_hi(base_hi), .size_mask(size_mask), .target(target), .attr(attr), .enable(enable)
  );

  logic [SIZE_W-1:0]  addr_hi;
  logic [NUM_WIN-1:0] win_hit;

  assign addr_hi = req_addr[GRAN_LSB +: SIZE_W];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
    awd_win_match #(.SIZE_W(SIZE_W)) u_match (
      .clk(clk), .rst_n(rst_n),
      .addr_hi(addr_hi), .base_hi(base_hi[i]), .size_mask(size_mask[i]),
      .enable(enable[i]), .hit(win_hit[i]), .size_err(cfg_err[i])
    );
  end

  logic [NUM_WIN-1:0] grant;
  logic [IDX_W-1:0]   win_idx;
  logic               any_hit;

  awd_prio_pick #(.N(NUM_WIN), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(win_hit),
    .grant(grant), .idx(win_idx), .any(any_hit)
  );

  // Route fields selected by the one-hot grant.
  logic [TGT_W-1:0]  sel_target;
  logic [ATTR_W-1:0] sel_attr;

  always_comb begin
    sel_target = '0;
    sel_attr   = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (grant[i]) begin
        sel_target = target[i];
        sel_attr   = attr[i];
      end
    end
  end

  logic take_hit;
  assign take_hit = req_valid && any_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_win    <= '0;
      rsp_target <= '0;
      rsp_attr   <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= take_hit;
      rsp_win    <= take_hit ? win_idx    : '0;
      rsp_target <= take_hit ? sel_target : '0;
      rsp_attr   <= take_hit ? sel_attr   : '0;
    end
  end

  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R9
  no_req_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R10
  miss_fields_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_win == '0 && rsp_target == '0 && rsp_attr == '0));

  // R9
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  // R9
  hit_index_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (int'(rsp_win) < NUM_WIN));

endmodule

// File: tb/tb_addr_window_decoder.sv
module tb_addr_window_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_win = '0;
  logic [1:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [2:0]  rsp_win;
  logic [3:0]  rsp_target;
  logic [7:0]  rsp_attr;
  logic [5:0]  cfg_err;

  addr_window_decoder dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
    .rsp_target(rsp_target), .rsp_attr(rsp_attr), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model state
  int m_base[NW];
  int m_size[NW];
  int m_tgt[NW];
  int m_attr[NW];
  bit m_en[NW];
  bit   e_valid, e_hit;
  int   e_win, e_tgt, e_attr;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit finished = 0;

  function automatic bit model_size_ok(int s);
    int k = 0;
    while (k < 16 && s[k]) k++;
    return (s >> k) == 0;
  endfunction

  function automatic bit model_match(int w, logic [31:0] a);
    longint span, lo;
    if (!m_en[w] || !model_size_ok(m_size[w])) return 0;
    span = (longint'(m_size[w]) + 1) * 65536;
    lo   = (longint'(m_base[w]) * 65536) / span * span;
    return (longint'(a) >= lo) && (longint'(a) < lo + span);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) begin
        m_base[i] = 0; m_size[i] = 0; m_tgt[i] = 0; m_attr[i] = 0; m_en[i] = 0;
      end
      e_valid = 0; e_hit = 0; e_win = 0; e_tgt = 0; e_attr = 0;
    end else begin
      e_valid = req_valid; e_hit = 0; e_win = 0; e_tgt = 0; e_attr = 0;
      if (req_valid) begin
        for (int i = NW - 1; i >= 0; i--) begin
          if (model_match(i, req_addr)) begin
            e_hit = 1; e_win = i; e_tgt = m_tgt[i]; e_attr = m_attr[i];
          end
        end
      end
      if (cfg_we && cfg_win < NW) begin
        case (cfg_field)
          2'd0: m_base[cfg_win] = int'(cfg_wdata[31:16]);
          2'd1: m_size[cfg_win] = int'(cfg_wdata[15:0]);
          2'd2: begin
            m_attr[cfg_win] = int'(cfg_wdata[7:0]);
            m_tgt[cfg_win]  = int'(cfg_wdata[11:8]);
          end
          default: m_en[cfg_win] = cfg_wdata[0];
        endcase
      end
    end
  end

  task automatic compare();
    int exp_err;
    exp_err = 0;
    for (int i = 0; i < NW; i++) if (!model_size_ok(m_size[i])) exp_err |= (1 << i);
    checks++;
    if (rsp_valid !== e_valid || rsp_hit !== e_hit || int'(rsp_win) != e_win ||
        int'(rsp_target) != e_tgt || int'(rsp_attr) != e_attr) begin
      errors++;
      $display("FAIL %s rsp v=%0d h=%0d w=%0d t=%0h a=%0h expected v=%0d h=%0d w=%0d t=%0h a=%0h",
               cur_req, rsp_valid, rsp_hit, rsp_win, rsp_target, rsp_attr,
               e_valid, e_hit, e_win, e_tgt, e_attr);
    end
    checks++;
    if (int'(cfg_err) != exp_err) begin
      errors++;
      $display("FAIL %s cfg_err=%0h expected %0h", cur_req, cfg_err, exp_err);
    end
  endtask

  // One cycle: compare outputs of the previous edge, then drive new inputs.
  task automatic cycle(bit we, int win, int fld, logic [31:0] wd, bit rv, logic [31:0] a);
    @(negedge clk);
    if (rst_n) compare();
    cfg_we = we; cfg_win = 3'(win); cfg_field = 2'(fld); cfg_wdata = wd;
    req_valid = rv; req_addr = a;
  endtask

  task automatic wr(int win, int fld, logic [31:0] wd);
    cycle(1, win, fld, wd, 0, '0);
  endtask

  task automatic rd(logic [31:0] a);
    cycle(0, 0, 0, '0, 1, a);
  endtask

  task automatic setup_win(int w, logic [31:0] base, int sz, int tgt, int at);
    wr(w, 0, base);
    wr(w, 1, 32'(sz));
    wr(w, 2, 32'((tgt << 8) | at));
    wr(w, 3, 32'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired, checks=%0d expected completion", checks);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, every address misses
    cur_req = "R1";
    checks++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || cfg_err !== 0) begin
      errors++;
      $display("FAIL R1 reset v=%0d h=%0d err=%0h expected 0 0 0", rsp_valid, rsp_hit, cfg_err);
    end
    rd(32'h0000_0000); rd(32'hFFFF_FFFF); rd(32'h9000_1234);

    // R2: field programming
    cur_req = "R2";
    setup_win(0, 32'h9000_0000, 16'h0FFF, 4, 8'hE8);
    setup_win(1, 32'hC000_0000, 16'h0000, 4, 8'hE0);
    setup_win(2, 32'hD800_0000, 16'h07FF, 1, 8'h2F);
    setup_win(3, 32'hE800_0000, 16'h00FF, 1, 8'h1E);
    setup_win(4, 32'hF800_0000, 16'h07FF, 1, 8'h0F);
    setup_win(5, 32'hFB00_0000, 16'h0000, 3, 8'h01);
    // R2: writes to windows 6 and 7 are ignored
    setup_win(6, 32'h1000_0000, 16'h0000, 7, 8'h77);
    setup_win(7, 32'h1000_0000, 16'h0000, 7, 8'h77);
    rd(32'h1000_0000);

    // R3, R5: 256 MB window and 16 MB window edges
    cur_req = "R3";
    rd(32'h9000_0000); rd(32'h9FFF_FFFF); rd(32'hA000_0000); rd(32'h8FFF_FFFF);
    cur_req = "R5";
    rd(32'hE800_0000); rd(32'hE8FF_FFFF); rd(32'hE900_0000); rd(32'hD800_0000);
    rd(32'hDFFF_FFFF);

    // R4: 64 KB window, low 16 bits ignored
    cur_req = "R4";
    rd(32'hC000_0000); rd(32'hC000_FFFF); rd(32'hC001_0000); rd(32'hBFFF_FFFF);

    // R8: window 5 lies inside window 4
    cur_req = "R8";
    rd(32'hFB00_0010); rd(32'hFB01_0000); rd(32'hF800_0000);

    // R7: disable window 4, window 5 now visible; disable window 1
    cur_req = "R7";
    wr(4, 3, 32'd0); rd(32'hFB00_0010); rd(32'hF800_0000);
    wr(1, 3, 32'd0); rd(32'hC000_0000);
    wr(4, 3, 32'd1); wr(1, 3, 32'd1);

    // R6: malformed size flagged, window ignored, then restored
    cur_req = "R6";
    wr(2, 1, 32'h0000_0F0F); rd(32'hD800_0000); rd(32'hD800_F000);
    wr(2, 1, 32'h0000_0002); rd(32'hD800_0000);
    wr(2, 1, 32'h0000_07FF); rd(32'hD800_0000);

    // R9: write in the same cycle as a request uses old settings
    cur_req = "R9";
    cycle(1, 0, 3, 32'd0, 1, 32'h9100_0000);
    rd(32'h9100_0000);
    cycle(1, 0, 3, 32'd1, 1, 32'h9100_0000);
    rd(32'h9100_0000);
    // R10: idle cycles and misses give zero fields
    cur_req = "R10";
    cycle(0, 0, 0, '0, 0, 32'h9000_0000);
    rd(32'h0000_0000);

    // Mixed random traffic near window bases
    cur_req = "R3";
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      int w;
      w = $urandom_range(0, NW - 1);
      a = {16'(m_base[w]), 16'h0} + ($urandom() & 32'h1FFF_FFFF) - 32'h0800_0000;
      cycle(0, 0, 0, '0, ($urandom_range(0, 3) != 0), a);
    end
    cycle(0, 0, 0, '0, 0, '0);
    cycle(0, 0, 0, '0, 0, '0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule